// File: doc/BRIEF.md
# Banked per-core countdown timer

This block holds one 32-bit down-counting timer for each processor core in a cluster. Software programs a timer through a plain word-wide register bus. It sets a start value, chooses a prescale divisor and one-shot or auto-reload operation, and starts the count. The counter steps down once every (divisor + 1) pulses of a shared prescaled-clock enable. When the count runs out, the timer raises a sticky flag, and that flag drives the core's own level interrupt line. Software drops the line by writing a one to the flag.

The bus space is split into 32-byte windows. Window 0 is an alias that reaches the timer of the core making the access, chosen by a requester ID sent with each access. Window i+1 reaches core i's timer no matter which core makes the access. Each window has four word registers:

- the reload value at byte 0x0
- the live count at 0x4
- control at 0x8
- the expiry flag at 0xC

Reads return data in the same cycle. Writes take effect on the clock edge that ends the access cycle.

Top module: `ptmr_bank`

## Requirements
- R1: After a synchronous active-low reset, every timer's reload value, count, control and flag read as zero, and every interrupt line is low.
- R2: A write to offset 0x0 sets the reload value and also copies it into the count. Offset 0x4 reads the live count. Offset 0x8 reads back only bit 0 (run), bit 1 (auto-reload) and bits [15:8] (divisor), with every other bit zero.
- R3: While run is 1 and the count is nonzero, the count drops by one on every (divisor + 1)-th cycle in which tick_en is high, counted from the last restart. While run is 0 the count holds.
- R4: With auto-reload 0, the step from 1 reaches 0 and sets the flag. The count then stays at 0.
- R5: With auto-reload 1, the step from 1 loads the reload value into the count instead and sets the flag, and counting goes on.
- R6: The interrupt line of each core is high exactly while its flag is set. Writing offset 0xC with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R7: A control write that changes run from 0 to 1 loads the reload value into the count when the count is 0 and the written auto-reload bit is 1. With auto-reload 0, the count stays 0.
- R8: A count write restarts the count from the written value. A reload-value write, or a 0-to-1 change of run, restarts it the same way. A restart also clears the prescale phase, so the next step comes a full (divisor + 1) ticks later.
- R9: Window 0 (address bits [7:5] = 0) reaches the timer of core bus_req_id. Window i+1 reaches core i. An alias access with bus_req_id ≥ NUM_CORES reaches no timer.
- R10: The following accesses read as zero and write nothing: offsets 0x10 to 0x1C, windows above NUM_CORES, and addresses whose bits [1:0] are not zero.
- R11: Each core's timer counts and flags on its own, and it drives only its own interrupt bit irq[i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Prescaled-clock enable, one pulse per prescaled period |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address: [7:5] window, [4:2] register, [1:0] must be 0 |
| bus_wdata | input | 32 | Write data |
| bus_req_id | input | 2 | Index of the core making the access |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | NUM_CORES | One level interrupt per core |

## Verification
A fault in the prescale phase shows up as a wrong count read back within one divisor period after a restart. The sweeps over small divisor and count values catch it there, often on the first tick. A reload or flag fault shows at the expiry tick: the next read of the count or the flag disagrees, and the interrupt line changes in that same cycle. A decode fault shows at once as the wrong core's register contents, or as nonzero data read from an unmapped address.

// File: rtl/ptmr_pkg.sv
// Package: shared constants for the banked countdown timer.
// Assumes at most MAX_CORES cores and 32-byte register windows.
package ptmr_pkg;
    localparam int MAX_CORES = 4;
    localparam int WIN_BITS  = 5;
    localparam int WIN_IDX_W = $clog2(MAX_CORES + 1);
    localparam int ADDR_W    = WIN_BITS + WIN_IDX_W;
    localparam int ID_W      = $clog2(MAX_CORES);
    localparam int DATA_W    = 32;
    localparam int DIV_W     = 8;

    localparam logic [2:0] REG_RELOAD = 3'd0;
    localparam logic [2:0] REG_COUNT  = 3'd1;
    localparam logic [2:0] REG_CTRL   = 3'd2;
    localparam logic [2:0] REG_FLAG   = 3'd3;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             reload;
        logic             run;
    } ctrl_t;
endpackage

// File: rtl/ptmr_prescale.sv
// Prescale phase counter: emits one step per (limit+1) ticks while active.
// Assumes the owner clears the phase on every restart.
module ptmr_prescale #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             active,
    input  logic             tick,
    input  logic [DIV_W-1:0] limit,
    output logic             step
);
    logic [DIV_W-1:0] phase_q;

    assign step = active && tick && (phase_q >= limit);

    // Advance the phase on each active tick; wrap on a step, zero on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q <= '0;
        end else if (active && tick) begin
            phase_q <= step ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/ptmr_decode.sv
// Address decoder: maps a bus access to at most one core's timer.
// Window 0 aliases the requester's own timer; window i+1 is core i.
module ptmr_decode
    import ptmr_pkg::*;
#(
    parameter int NUM_CORES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [ID_W-1:0]      req_id,
    output logic [NUM_CORES-1:0] hit,
    output logic [2:0]           reg_idx
);
    logic [WIN_IDX_W-1:0] win;
    logic                 aligned;

    assign win     = addr[ADDR_W-1:WIN_BITS];
    assign aligned = (addr[1:0] == 2'b00);
    assign reg_idx = addr[4:2];

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_hit
        assign hit[i] = sel && aligned &&
                        (((win == '0) && (req_id == ID_W'(i))) ||
                         (win == WIN_IDX_W'(i + 1)));
    end

    // R9
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: rtl/ptmr_unit.sv
// One core's countdown timer: reload value, count, control and expiry flag.
// Assumes at most one register written per cycle; a write suppresses that cycle's step.
module ptmr_unit
    import ptmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              acc_wr,
    input  logic [2:0]        reg_idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [DATA_W-1:0] reload_q, count_q;
    ctrl_t             ctrl_q;
    logic              flag_q;
    logic              wr_reload, wr_count, wr_ctrl, wr_flag;
    logic              run_rise, restart, active, step;

    assign wr_reload = acc_wr && (reg_idx == REG_RELOAD);
    assign wr_count  = acc_wr && (reg_idx == REG_COUNT);
    assign wr_ctrl   = acc_wr && (reg_idx == REG_CTRL);
    assign wr_flag   = acc_wr && (reg_idx == REG_FLAG);
    assign run_rise  = wr_ctrl && !ctrl_q.run && wdata[0];
    assign restart   = wr_reload || wr_count || run_rise;
    assign active    = ctrl_q.run && (count_q != '0) && !acc_wr;

    ptmr_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(restart), .active(active),
        .tick(tick), .limit(ctrl_q.div), .step(step)
    );

    // Register writes take priority; otherwise apply a prescaled step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            count_q  <= '0;
            ctrl_q   <= '0;
            flag_q   <= 1'b0;
        end else if (wr_reload) begin
            reload_q <= wdata;
            count_q  <= wdata;
        end else if (wr_count) begin
            count_q <= wdata;
        end else if (wr_ctrl) begin
            ctrl_q <= '{div: wdata[15:8], reload: wdata[1], run: wdata[0]};
            if (run_rise && (count_q == '0) && wdata[1]) begin
                count_q <= reload_q;
            end
        end else if (wr_flag) begin
            if (wdata[0]) flag_q <= 1'b0;
        end else if (step) begin
            if (count_q == 1) begin
                flag_q  <= 1'b1;
                count_q <= ctrl_q.reload ? reload_q : '0;
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    // Return the addressed register; unlisted offsets read zero.
    always_comb begin
        case (reg_idx)
            REG_RELOAD: rdata = reload_q;
            REG_COUNT:  rdata = count_q;
            REG_CTRL:   rdata = {16'h0, ctrl_q.div, 6'h0, ctrl_q.reload, ctrl_q.run};
            REG_FLAG:   rdata = {31'h0, flag_q};
            default:    rdata = '0;
        endcase
    end

    assign irq = flag_q;

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !acc_wr) |=> $stable(count_q));
    // R4
    zero_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && !acc_wr) |=> (count_q == '0));
    // R4
    expiry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count_q == 1) |=> flag_q);
    // R5
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count_q == 1 && ctrl_q.reload) |=> (count_q == $past(reload_q)));
    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && wdata[0]) |=> !irq);
endmodule

// File: rtl/ptmr_bank.sv
// Top: NUM_CORES countdown timers behind a window decoder with a per-requester alias.
// Assumes 1 <= NUM_CORES <= MAX_CORES and word-aligned accesses only.
module ptmr_bank
    import ptmr_pkg::*;
#(
    parameter int NUM_CORES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [ID_W-1:0]      bus_req_id,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_CORES-1:0] irq
);
    logic [NUM_CORES-1:0] hit;
    logic [2:0]           reg_idx;
    logic [DATA_W-1:0]    unit_rd [NUM_CORES];

    ptmr_decode #(.NUM_CORES(NUM_CORES)) u_dec (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .addr(bus_addr),
        .req_id(bus_req_id), .hit(hit), .reg_idx(reg_idx)
    );

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_unit
        ptmr_unit u_tmr (
            .clk(clk), .rst_n(rst_n), .tick(tick_en),
            .acc_wr(hit[i] && bus_wr), .reg_idx(reg_idx), .wdata(bus_wdata),
            .rdata(unit_rd[i]), .irq(irq[i])
        );
    end

    // Merge read data from the single selected timer; zero when none.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (hit[i] && !bus_wr) bus_rdata = bus_rdata | unit_rd[i];
        end
    end
endmodule

// File: tb/ptmr_bank_test.sv
`timescale 1ns/1ps
module ptmr_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_req_id = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    ptmr_bank #(.NUM_CORES(2)) uut (.*);

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int win, input int off, input logic [31:0] d, input int id);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 8'(win * 32 + off);
        bus_wdata = d; bus_req_id = 2'(id);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input int win, input int off, input int id, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = 8'(win * 32 + off); bus_req_id = 2'(id);
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic run(input int k);
        tick_en = 1;
        repeat (k) @(negedge clk);
        tick_en = 0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state on both cores
        for (int w = 1; w <= 2; w++)
            for (int o = 0; o < 16; o += 4) begin
                rd(w, o, 0, v); chk("R1 reg after reset", v, 0);
            end
        chk("R1 irq after reset", 32'(irq), 0);

        // R2 reload write copies into count; control readback mask
        wr(1, 0, 32'hDEAD_BEEF, 0);
        rd(1, 0, 0, v); chk("R2 reload value", v, 32'hDEAD_BEEF);
        rd(1, 4, 0, v); chk("R2 count copy", v, 32'hDEAD_BEEF);
        wr(1, 8, 32'hFFFF_FFFF, 0);
        rd(1, 8, 0, v); chk("R2 control readback", v, 32'h0000_FF03);
        wr(1, 8, 0, 0);

        // R3 run=0 holds the count
        wr(1, 0, 7, 0); run(10);
        rd(1, 4, 0, v); chk("R3 hold while stopped", v, 7);

        // R3 R4 one-shot sweep over divisor and count
        for (int p = 0; p < 4; p++)
            for (int c = 1; c <= 3; c++) begin
                wr(1, 8, 0, 0); wr(1, 12, 1, 0); wr(1, 0, c, 0);
                wr(1, 8, (p << 8) | 1, 0);
                for (int k = 1; k <= c * (p + 1) + 2; k++) begin
                    int d;
                    run(1);
                    d = k / (p + 1);
                    rd(1, 4, 0, v);
                    chk("R4 one-shot count", v, (d >= c) ? 0 : c - d);
                    chk("R4 one-shot irq", 32'(irq[0]), (d >= c) ? 1 : 0);
                end
            end

        // R6 flag write-one-to-clear; irq follows flag
        wr(1, 12, 32'hFFFF_FFFE, 0);
        rd(1, 12, 0, v); chk("R6 zero write keeps flag", v, 1);
        chk("R6 irq held", 32'(irq[0]), 1);
        wr(1, 12, 1, 0);
        rd(1, 12, 0, v); chk("R6 flag cleared", v, 0);
        chk("R6 irq dropped", 32'(irq[0]), 0);

        // R5 auto-reload sweep
        for (int l = 1; l <= 3; l++)
            for (int p = 0; p < 3; p++) begin
                wr(1, 8, 0, 0); wr(1, 12, 1, 0); wr(1, 0, l, 0);
                wr(1, 8, (p << 8) | 3, 0);
                for (int k = 1; k <= 3 * l * (p + 1); k++) begin
                    int d;
                    run(1);
                    d = k / (p + 1);
                    rd(1, 4, 0, v);
                    chk("R5 reload count", v, l - (d % l));
                    chk("R5 reload irq", 32'(irq[0]), (d >= l) ? 1 : 0);
                end
            end

        // R7 enable rise with zero count
        wr(1, 8, 0, 0); wr(1, 0, 4, 0); wr(1, 8, 1, 0); run(5);
        rd(1, 4, 0, v); chk("R7 expired to zero", v, 0);
        wr(1, 8, 0, 0); wr(1, 8, 3, 0);
        rd(1, 4, 0, v); chk("R7 rise with reload loads", v, 4);
        wr(1, 8, 0, 0); wr(1, 4, 0, 0); wr(1, 8, 1, 0);
        rd(1, 4, 0, v); chk("R7 rise without reload stays", v, 0);

        // R8 count write restarts and clears prescale phase
        wr(1, 8, 0, 0); wr(1, 0, 10, 0); wr(1, 8, 32'h0000_0101, 0);
        run(3);
        rd(1, 4, 0, v); chk("R8 before restart", v, 9);
        wr(1, 4, 5, 0); run(1);
        rd(1, 4, 0, v); chk("R8 phase cleared", v, 5);
        run(1);
        rd(1, 4, 0, v); chk("R8 step after restart", v, 4);
        wr(1, 8, 0, 0); wr(1, 12, 1, 0);

        // R9 alias window by requester ID
        wr(1, 0, 32'h11, 0); wr(2, 0, 32'h5, 0);
        rd(0, 0, 1, v); chk("R9 alias core1", v, 32'h5);
        rd(0, 0, 0, v); chk("R9 alias core0", v, 32'h11);
        wr(0, 0, 32'h22, 1);
        rd(2, 0, 0, v); chk("R9 alias write core1", v, 32'h22);
        rd(1, 0, 0, v); chk("R9 core0 untouched", v, 32'h11);
        rd(0, 0, 2, v); chk("R9 bad id reads zero", v, 0);
        wr(0, 0, 32'h99, 2);
        rd(1, 0, 0, v); chk("R9 bad id no write core0", v, 32'h11);
        rd(2, 0, 0, v); chk("R9 bad id no write core1", v, 32'h22);

        // R10 unmapped offsets, windows, misaligned
        rd(1, 16, 0, v); chk("R10 offset 0x10 reads zero", v, 0);
        wr(1, 20, 32'hFFFF_FFFF, 0);
        rd(1, 0, 0, v); chk("R10 reload after 0x14 write", v, 32'h11);
        rd(1, 8, 0, v); chk("R10 control after 0x14 write", v, 0);
        rd(3, 0, 0, v); chk("R10 window 3 reads zero", v, 0);
        wr(3, 0, 32'h77, 0);
        rd(1, 0, 0, v); chk("R10 window 3 write core0", v, 32'h11);
        rd(2, 0, 0, v); chk("R10 window 3 write core1", v, 32'h22);
        wr(1, 1, 32'h77, 0);
        rd(1, 0, 0, v); chk("R10 misaligned write ignored", v, 32'h11);
        rd(1, 1, 0, v); chk("R10 misaligned read zero", v, 0);

        // R11 independent interrupt lines
        wr(2, 0, 2, 0); wr(2, 8, 1, 0); run(2);
        chk("R11 only core1 irq", 32'(irq), 2);
        rd(1, 4, 0, v); chk("R11 core0 count untouched", v, 32'h11);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule